// File: doc/BRIEF.md
# Transceiver Power-Up Calibration Sequencer

This controller sits next to a baseband processor and brings a 2.4 GHz FSK radio into a calibrated state after power-up. On a start pulse it samples a 3-bit reference-frequency code and a channel index. It then sends seven write packets over a three-wire serial port.

The first packet programs the synthesizer control register. It carries the reference code, the transmit-enable bit and a 7-bit frequency offset computed from the channel. Six writes to the chip-control register follow. They step the radio through crystal power-up and its internal calibrations, then hand control back to the radio's own state machine. After each of these writes the sequencer waits the settle time required for that step. The waits are counted in microseconds, with a tick derived from the system clock.

While the script runs, `busy` is high. When the last packet has been sent and latched, `done` rises and stays high until the next start.

Top module: `radio_cal_seq`

## Requirements
- R1: Every packet holds 25 bits, sent MSB first, with the enable line low throughout. The bits are: device code 101 in bits 24:22, a write flag of 0 in bit 21, a 5-bit register address in bits 20:16, and 16 data bits in bits 15:0.
- R2: The serial clock idles high. The data line changes only in the cycle where the serial clock falls, so the slave samples a stable bit on each of the 25 rising edges.
- R3: After the enable line returns high, exactly one further serial clock pulse is sent (a fall, then a rise) before the next packet begins.
- R4: The first packet goes to address 7. Its data is: bits 15:12 zero, bits 11:9 the sampled reference code, bit 8 (transmit enable) one, bit 7 zero, and bits 6:0 the synthesizer offset.
- R5: The synthesizer offset is the channel index plus 3, which is the local oscillator frequency minus 2400 MHz. Channel indices above 78 are treated as 78, so the offset always lies in 3..81.
- R6: Packets two to seven go to address 5 and carry, in order: 16'h80C0, 16'h84C0, 16'h8AC5, 16'h80E5, 16'h80D4 and 16'h0000.
- R7: Let W be the settle time in microseconds that follows packet k. W is 0, 2500, 1024, 285, 608 and 64 for k = 1..6. The enable line of packet k+1 falls exactly W*TICKS_PER_US + 3*HALF_DIV + 2 clock cycles after the enable line of packet k rises. The settle times add up to 4481 us.
- R8: `busy` rises in the cycle after a start pulse is accepted. `busy` falls and `done` rises 3*HALF_DIV + 1 cycles after the enable line of the final packet rises. `done` then stays high until the next accepted start, which clears it.
- R9: A start pulse while `busy` is high is ignored. The channel and reference code are captured only when a start is accepted, so later changes to them have no effect on the running script.
- R10: Out of reset, the serial clock is 1, enable is 1, data is 0, and `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to run the script |
| ref_code | input | 3 | Reference-divider code placed in bits 11:9 of the first write |
| chan | input | CH_W | Channel index, 0..78 valid, larger values clamped |
| ser_clk | output | 1 | Serial port clock |
| ser_data | output | 1 | Serial port data, master to radio |
| ser_en_n | output | 1 | Serial port enable, low during a packet |
| busy | output | 1 | Script in progress |
| done | output | 1 | Script finished, held until next start |

## Verification
Each packet's timing follows from a fixed chain of registers. The bench therefore timestamps every enable edge, counted in cycles, and requires each gap to equal W*TICKS_PER_US + 3*HALF_DIV + 2 to within one cycle. The rise of `done` is likewise checked against 3*HALF_DIV + 1 cycles after the last enable rise. Packet bits are captured on the rising edges of the serial clock and compared with words computed arithmetically from the channel and reference code. The sweep covers the channel ends, the clamp boundary and all five reference codes, and one run applies a second start with altered inputs mid-script. All sampling happens on the falling system clock edge, half a cycle away from register updates.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    localparam logic [2:0] DEV_CODE   = 3'b101;
    localparam int         STEPS      = 7;
    localparam int         STEP_W     = 3;
    localparam int         PKT_W      = 25;
    localparam int         CH_MAX     = 78;
    localparam int         OFF_BASE   = 3;
    localparam int         WAIT_MAX   = 2500;
    localparam int         WAIT_W     = $clog2(WAIT_MAX + 1);
    localparam logic [4:0] ADDR_SYNTH = 5'd7;
    localparam logic [4:0] ADDR_CTRL  = 5'd5;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_SEND, SQ_WAIT_TX, SQ_SETTLE, SQ_NEXT
    } seq_state_e;

    typedef enum logic [2:0] {
        TX_IDLE, TX_SETUP, TX_BLO, TX_BHI, TX_ENDH, TX_TLO, TX_THI
    } tx_state_e;

    function automatic logic [15:0] step_data(input logic [STEP_W-1:0] idx,
                                              input logic [15:0] synth_word);
        case (idx)
            3'd0:    return synth_word;
            3'd1:    return 16'h80C0;
            3'd2:    return 16'h84C0;
            3'd3:    return 16'h8AC5;
            3'd4:    return 16'h80E5;
            3'd5:    return 16'h80D4;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [4:0] step_addr(input logic [STEP_W-1:0] idx);
        return (idx == '0) ? ADDR_SYNTH : ADDR_CTRL;
    endfunction

    function automatic logic [WAIT_W-1:0] step_wait(input logic [STEP_W-1:0] idx);
        case (idx)
            3'd1:    return WAIT_W'(2500);
            3'd2:    return WAIT_W'(1024);
            3'd3:    return WAIT_W'(285);
            3'd4:    return WAIT_W'(608);
            3'd5:    return WAIT_W'(64);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/rcs_chan_map.sv
module rcs_chan_map
    import rcs_pkg::*;
#(
    parameter int CH_W = 7
) (
    input  logic [2:0]      ref_code_i,
    input  logic [CH_W-1:0] chan_i,
    output logic [15:0]     synth_word_o
);
    logic [6:0] off;

    always_comb begin
        if (int'(chan_i) > CH_MAX) off = 7'(CH_MAX + OFF_BASE);
        else                       off = 7'(chan_i) + 7'(OFF_BASE);
        synth_word_o = {4'b0000, ref_code_i, 1'b1, 1'b0, off};
    end

endmodule

// File: rtl/rcs_tick.sv
module rcs_tick #(
    parameter int TICKS_PER_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int TW = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tick_reg_t;

    tick_reg_t q, d;

    always_comb begin
        d      = q;
        tick_o = en_i && (q.cnt == TW'(TICKS_PER_US - 1));
        if (!en_i || tick_o) d.cnt = '0;
        else                 d.cnt = q.cnt + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R7
    tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= TW'(TICKS_PER_US - 1));

endmodule

// File: rtl/rcs_serial_tx.sv
module rcs_serial_tx
    import rcs_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             send_i,
    input  logic [PKT_W-1:0] word_i,
    output logic             ready_o,
    output logic             fin_o,
    output logic             sclk_o,
    output logic             sdata_o,
    output logic             sen_n_o
);
    localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BW = $clog2(PKT_W + 1);

    typedef struct packed {
        tx_state_e        state;
        logic [HW-1:0]    hcnt;
        logic [BW-1:0]    bcnt;
        logic [PKT_W-1:0] sreg;
        logic             sclk;
        logic             sdata;
        logic             sen_n;
    } tx_reg_t;

    tx_reg_t q, d;
    logic    phase_end;

    always_comb begin
        d         = q;
        fin_o     = 1'b0;
        phase_end = (q.hcnt == HW'(HALF_DIV - 1));
        d.hcnt    = phase_end ? '0 : q.hcnt + HW'(1);
        case (q.state)
            TX_IDLE: begin
                d.hcnt = '0;
                if (send_i) begin
                    d.state = TX_SETUP;
                    d.sreg  = word_i;
                    d.bcnt  = '0;
                    d.sen_n = 1'b0;
                end
            end
            TX_SETUP: if (phase_end) begin
                d.state = TX_BLO;
                d.sclk  = 1'b0;
                d.sdata = q.sreg[PKT_W-1];
                d.sreg  = q.sreg << 1;
            end
            TX_BLO: if (phase_end) begin
                d.state = TX_BHI;
                d.sclk  = 1'b1;
                d.bcnt  = q.bcnt + BW'(1);
            end
            TX_BHI: if (phase_end) begin
                if (q.bcnt == BW'(PKT_W)) begin
                    d.state = TX_ENDH;
                    d.sen_n = 1'b1;
                end else begin
                    d.state = TX_BLO;
                    d.sclk  = 1'b0;
                    d.sdata = q.sreg[PKT_W-1];
                    d.sreg  = q.sreg << 1;
                end
            end
            TX_ENDH: if (phase_end) begin
                d.state = TX_TLO;
                d.sclk  = 1'b0;
            end
            TX_TLO: if (phase_end) begin
                d.state = TX_THI;
                d.sclk  = 1'b1;
            end
            TX_THI: if (phase_end) begin
                d.state = TX_IDLE;
                fin_o   = 1'b1;
            end
            default: d.state = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= TX_IDLE;
            q.sclk  <= 1'b1;
            q.sen_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ready_o = (q.state == TX_IDLE);
    assign sclk_o  = q.sclk;
    assign sdata_o = q.sdata;
    assign sen_n_o = q.sen_n;

    // R2
    data_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sclk && $past(q.sclk)) |-> $stable(q.sdata));

    // R3
    en_rise_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sen_n) |-> q.sclk);

    // R1
    bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.sen_n |-> (q.bcnt <= BW'(PKT_W)));

endmodule

// File: rtl/radio_cal_seq.sv
module radio_cal_seq
    import rcs_pkg::*;
#(
    parameter int TICKS_PER_US = 100,
    parameter int HALF_DIV     = 4,
    parameter int CH_W         = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      ref_code,
    input  logic [CH_W-1:0] chan,
    output logic            ser_clk,
    output logic            ser_data,
    output logic            ser_en_n,
    output logic            busy,
    output logic            done
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [STEP_W-1:0] step;
        logic [WAIT_W-1:0] us_cnt;
        logic [2:0]        ref_c;
        logic [CH_W-1:0]   chan_c;
        logic              busy;
        logic              done;
    } seq_reg_t;

    seq_reg_t          q, d;
    logic              tick, tick_en;
    logic              tx_send, tx_ready, tx_fin;
    logic [15:0]       synth_word;
    logic [WAIT_W-1:0] cur_wait;
    logic [PKT_W-1:0]  pkt_word;

    rcs_chan_map #(.CH_W(CH_W)) u_map (
        .ref_code_i   (q.ref_c),
        .chan_i       (q.chan_c),
        .synth_word_o (synth_word)
    );

    rcs_tick #(.TICKS_PER_US(TICKS_PER_US)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tick_en),
        .tick_o (tick)
    );

    rcs_serial_tx #(.HALF_DIV(HALF_DIV)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .send_i  (tx_send),
        .word_i  (pkt_word),
        .ready_o (tx_ready),
        .fin_o   (tx_fin),
        .sclk_o  (ser_clk),
        .sdata_o (ser_data),
        .sen_n_o (ser_en_n)
    );

    always_comb begin
        d        = q;
        tx_send  = 1'b0;
        tick_en  = (q.state == SQ_SETTLE);
        cur_wait = step_wait(q.step);
        pkt_word = {DEV_CODE, 1'b0, step_addr(q.step), step_data(q.step, synth_word)};
        case (q.state)
            SQ_IDLE: if (start) begin
                d.state  = SQ_SEND;
                d.step   = '0;
                d.ref_c  = ref_code;
                d.chan_c = chan;
                d.busy   = 1'b1;
                d.done   = 1'b0;
            end
            SQ_SEND: if (tx_ready) begin
                tx_send = 1'b1;
                d.state = SQ_WAIT_TX;
            end
            SQ_WAIT_TX: if (tx_fin) begin
                d.us_cnt = '0;
                d.state  = (cur_wait == '0) ? SQ_NEXT : SQ_SETTLE;
            end
            SQ_SETTLE: if (tick) begin
                if (q.us_cnt == cur_wait - WAIT_W'(1)) d.state = SQ_NEXT;
                else d.us_cnt = q.us_cnt + WAIT_W'(1);
            end
            SQ_NEXT: begin
                if (q.step == LAST_STEP) begin
                    d.state = SQ_IDLE;
                    d.busy  = 1'b0;
                    d.done  = 1'b1;
                end else begin
                    d.step  = q.step + STEP_W'(1);
                    d.state = SQ_SEND;
                end
            end
            default: d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= SQ_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy = q.busy;
    assign done = q.done;

    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R8
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(q.ref_c) && $stable(q.chan_c)));

    // R5
    off_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (synth_word[6:0] >= 7'd3 && synth_word[6:0] <= 7'd81));

    // R7
    settle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SQ_SETTLE) |-> (q.us_cnt < cur_wait));

endmodule

// File: tb/sim_radio_cal_seq.sv
module sim_radio_cal_seq;

    localparam int T  = 2;
    localparam int H  = 2;
    localparam int CW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    ref_code = 3'b011;
    logic [CW-1:0] chan = '0;
    logic          ser_clk, ser_data, ser_en_n, busy, done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 1'b0;

    logic [24:0] pk_word  [16];
    int          pk_bits  [16];
    int          pk_t0    [16];
    int          pk_t1    [16];
    int          pk_trail [16];
    int          npk = 0;
    logic [24:0] shreg = '0;
    int          nbits = 0;
    logic        p_clk = 1'b1;
    logic        p_en = 1'b1;

    radio_cal_seq #(.TICKS_PER_US(T), .HALF_DIV(H), .CH_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_code(ref_code), .chan(chan),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_en_n(ser_en_n),
        .busy(busy), .done(done)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (p_en && !ser_en_n) begin
            pk_t0[npk] = cyc;
            nbits = 0;
            shreg = '0;
        end
        if (!ser_en_n && !p_clk && ser_clk) begin
            shreg = {shreg[23:0], ser_data};
            nbits++;
        end
        if (!p_en && ser_en_n) begin
            pk_word[npk]  = shreg;
            pk_bits[npk]  = nbits;
            pk_t1[npk]    = cyc;
            pk_trail[npk] = 0;
            if (npk < 15) npk++;
        end
        if (p_en && ser_en_n && p_clk && !ser_clk && npk > 0)
            pk_trail[npk-1]++;
        p_clk = ser_clk;
        p_en  = ser_en_n;
    end

    always @(posedge clk) begin
        if (cyc > 190000 && !finished) begin
            fails++;
            $display("FAIL R8 watchdog actual=%0d expected=<190000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int wait_us(input int k);
        case (k)
            1: return 2500;
            2: return 1024;
            3: return 285;
            4: return 608;
            5: return 64;
            default: return 0;
        endcase
    endfunction

    function automatic logic [24:0] exp_pkt(input int k, input logic [2:0] rc, input int ch);
        logic [15:0] d;
        int off;
        off = ((ch > 78) ? 78 : ch) + 3;
        case (k)
            0: d = {4'b0, rc, 1'b1, 1'b0, 7'(off)};
            1: d = 16'h80C0;
            2: d = 16'h84C0;
            3: d = 16'h8AC5;
            4: d = 16'h80E5;
            5: d = 16'h80D4;
            default: d = 16'h0000;
        endcase
        return {3'b101, 1'b0, (k == 0) ? 5'd7 : 5'd5, d};
    endfunction

    task automatic run_seq(input logic [2:0] rc, input int ch, input bit poke);
        int t_done;
        int guard;
        npk = 0;
        ref_code = rc;
        chan = CW'(ch);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8 busy after start", busy, 1);
        chk(done == 1'b0, "R8 done cleared by start", done, 0);
        if (poke) begin
            guard = 0;
            while (npk < 2 && guard < 20000) begin @(negedge clk); guard++; end
            chan = CW'(5);
            ref_code = 3'b111;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R9 start while busy keeps run", busy, 1);
        end
        guard = 0;
        while (!done && guard < 20000) begin @(negedge clk); guard++; end
        t_done = cyc;
        chk(npk == 7, "R9 packet count", npk, 7);
        for (int k = 0; k < 7; k++) begin
            chk(pk_bits[k] == 25, "R1 bits per packet", pk_bits[k], 25);
            chk(pk_word[k] == exp_pkt(k, rc, ch), (k == 0) ? "R4 R5 synth packet" : "R6 ctrl packet",
                pk_word[k], exp_pkt(k, rc, ch));
            chk(pk_trail[k] == 1, "R3 trailing pulse", pk_trail[k], 1);
        end
        for (int k = 0; k < 6; k++) begin
            int gap, eg;
            gap = pk_t0[k+1] - pk_t1[k];
            eg  = wait_us(k) * T + 3 * H + 2;
            chk(gap >= eg - 1 && gap <= eg + 1, "R7 settle gap", gap, eg);
        end
        chk((t_done - pk_t1[6]) >= 3*H && (t_done - pk_t1[6]) <= 3*H + 2,
            "R8 done timing", t_done - pk_t1[6], 3*H + 1);
        chk(busy == 1'b0, "R8 busy low at done", busy, 0);
        repeat (5) @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0, "R8 done held", done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ser_clk == 1'b1, "R10 reset sclk", ser_clk, 1);
        chk(ser_en_n == 1'b1, "R10 reset enable", ser_en_n, 1);
        chk(ser_data == 1'b0, "R10 reset data", ser_data, 0);
        chk(busy == 1'b0 && done == 1'b0, "R10 reset busy/done", {busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ser_clk == 1'b1 && ser_en_n == 1'b1, "R2 idle clock high", {ser_clk, ser_en_n}, 3);
        run_seq(3'b011, 0,   1'b0);
        run_seq(3'b100, 1,   1'b0);
        run_seq(3'b101, 46,  1'b0);
        run_seq(3'b110, 77,  1'b0);
        run_seq(3'b111, 78,  1'b0);
        run_seq(3'b011, 79,  1'b0);
        run_seq(3'b100, 127, 1'b0);
        run_seq(3'b110, 45,  1'b1);
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule